// File: doc/BRIEF.md
# Switch Control Window Register Decoder

This block sits behind a 32-bit host register port and decodes the device's control window. Each access presents a byte offset, a write strobe and write data. Reads are combinational: the read data follows the offset within the same cycle. Writes take effect at the rising clock edge.

The window holds several kinds of location. A low guard range returns a fixed signature, so that a misbehaving driver is easy to spot. Two loopback test registers, one 32 bits wide and one 64 bits wide, read back twice the value last written to them. A trigger register turns a written vector number into a one-cycle interrupt request. A 64-bit enable bitmap drives the front-panel ports, and a 64-bit read-only view shows the per-port link inputs.

A 64-bit location is reached through two aligned 32-bit words, the lower word first and then the upper word. A write to the lower word is only staged. The whole 64-bit value is committed when the upper word is written. Every offset that is not mapped, and every offset that is not word-aligned outside the guard range, reads as zero and ignores writes.

Top module: `swdev_regdecode`

## Requirements
- R1: Any offset below 0x10 reads 0xDEADBABE, and a write there changes no other register.
- R2: An unmapped offset, or a non-word-aligned offset at or above 0x10, reads 0 and a write there changes no register, output or interrupt.
- R3: The 32-bit test register at 0x10 reads (2 × last written value) mod 2^32 and reads 0 after reset.
- R4: The 64-bit test register reads (2 × committed value) mod 2^64, with the low half at 0x18 and the high half at 0x1C. It reads 0 after reset.
- R5: For a 64-bit register, a write to the low word alone does not change the read value or the outputs. A later write to the high word commits {high word, most recent staged low word}.
- R6: A write to 0x20 raises irq_valid_o for exactly the next cycle, with irq_vector_o equal to write data bits [7:0]. Reading 0x20 returns that vector zero-extended.
- R7: The port enable bitmap (low half at 0x318, high half at 0x31C) resets to 0. Bits 0 and 63 always read 0 and are always 0 on port_en_o.
- R8: The link status view (low half at 0x310, high half at 0x314) shows link_up_i bits 1 to 62 and 0 in bits 0 and 63. Writes to it are ignored.
- R9: port_en_o always equals the committed port enable bitmap that is read back at 0x318/0x31C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Write strobe for the current offset |
| host_addr | input | ADDR_W (13) | Byte offset into the window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr, combinational |
| link_up_i | input | 64 | Per-port link-up levels, bits 0 and 63 unused |
| port_en_o | output | 64 | Committed port enable bitmap |
| irq_valid_o | output | 1 | One-cycle test interrupt request |
| irq_vector_o | output | 8 | Vector of the last test interrupt |

## Verification
The hardest state to reach is a 64-bit register whose low word has been staged but whose high word has not yet arrived. It is harder still when unrelated writes and reads come in between, or when a second low write replaces the staged value before the commit. The stimulus reaches this state in two ways. Directed sequences split the two halves with writes elsewhere. Random writes then pick the low and high words of both 64-bit registers independently, so stage, overwrite and commit orders mix freely. The reference model keeps its own staged copies and checks that nothing moves until the high word lands.

// File: rtl/swdev_reg_pkg.sv
// Package: offsets and constants shared by the control window decoder.
// Assumes byte offsets, 32-bit words, 64-bit registers split low/high.
package swdev_reg_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned VEC_W    = 8;
    localparam int unsigned PORT_W   = 64;
    localparam logic [WORD_W-1:0] TRAP_SIG = 32'hDEAD_BABE;
    localparam logic [15:0] GUARD_END = 16'h0010;
    localparam logic [15:0] OFF_T32   = 16'h0010;
    localparam logic [15:0] OFF_T64LO = 16'h0018;
    localparam logic [15:0] OFF_T64HI = 16'h001C;
    localparam logic [15:0] OFF_IRQ   = 16'h0020;
    localparam logic [15:0] OFF_LNKLO = 16'h0310;
    localparam logic [15:0] OFF_LNKHI = 16'h0314;
    localparam logic [15:0] OFF_PENLO = 16'h0318;
    localparam logic [15:0] OFF_PENHI = 16'h031C;
    // Ports 0 and 63 are not front-panel ports
    localparam logic [PORT_W-1:0] PORT_MASK = {1'b0, {(PORT_W-2){1'b1}}, 1'b0};

    typedef enum logic [3:0] {
        SEL_NONE, SEL_TRAP, SEL_T32, SEL_T64LO, SEL_T64HI, SEL_IRQ,
        SEL_LNKLO, SEL_LNKHI, SEL_PENLO, SEL_PENHI
    } reg_sel_e;
endpackage

// File: rtl/swdev_stage64.sv
// Staged wide register: a low-word write is held in a staging register, and
// a high-word write commits {high, staged low} masked by KEEP_MASK.
// Assumes the host writes the low word before the high word.
module swdev_stage64 #(
    parameter int unsigned HALF_W = 32,
    parameter logic [2*HALF_W-1:0] KEEP_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] value_o
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    logic [HALF_W-1:0] staged_q;
    logic [FULL_W-1:0] value_q;

    // Capture the low word into staging
    always_ff @(posedge clk) begin
        if (!rst_n)     staged_q <= '0;
        else if (lo_we) staged_q <= wdata;
    end

    // Commit the whole value when the high word arrives
    always_ff @(posedge clk) begin
        if (!rst_n)     value_q <= '0;
        else if (hi_we) value_q <= {wdata, staged_q} & KEEP_MASK;
    end

    assign value_o = value_q;

    // R5
    hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |=> $stable(value_o));
    // R7
    masked_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (value_o & ~KEEP_MASK) == '0);
endmodule

// File: rtl/swdev_irq_pulse.sv
// Test interrupt generator: a trigger produces a one-cycle valid pulse in the
// following cycle and latches the vector, which stays readable afterwards.
module swdev_irq_pulse #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [VEC_W-1:0] vec_in,
    output logic             valid_o,
    output logic [VEC_W-1:0] vector_o
);
    logic             valid_q;
    logic [VEC_W-1:0] vec_q;

    // Register the pulse and the vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
        end else begin
            valid_q <= trig;
            if (trig) vec_q <= vec_in;
        end
    end

    assign valid_o  = valid_q;
    assign vector_o = vec_q;

    // R6
    vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(vector_o));
endmodule

// File: rtl/swdev_regdecode.sv
// Control window decoder: maps a byte offset onto the guard range, the test
// registers, the interrupt trigger and the port bitmaps. Reads are
// combinational; writes act on the rising edge. Assumes one access per cycle.
module swdev_regdecode
    import swdev_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [63:0]       link_up_i,
    output logic [63:0]       port_en_o,
    output logic              irq_valid_o,
    output logic [7:0]        irq_vector_o
);
    localparam int unsigned HALF_W = WORD_W;

    reg_sel_e          sel;
    logic [WORD_W-1:0] t32_q;
    logic [63:0]       t64_val;
    logic [63:0]       t64_dbl;
    logic [63:0]       pen_val;
    logic [63:0]       lnk_view;

    // Decode the offset into a register select
    always_comb begin
        sel = SEL_NONE;
        if (host_addr < GUARD_END[ADDR_W-1:0]) begin
            sel = SEL_TRAP;
        end else if (host_addr[1:0] == 2'b00) begin
            case (host_addr)
                OFF_T32[ADDR_W-1:0]:   sel = SEL_T32;
                OFF_T64LO[ADDR_W-1:0]: sel = SEL_T64LO;
                OFF_T64HI[ADDR_W-1:0]: sel = SEL_T64HI;
                OFF_IRQ[ADDR_W-1:0]:   sel = SEL_IRQ;
                OFF_LNKLO[ADDR_W-1:0]: sel = SEL_LNKLO;
                OFF_LNKHI[ADDR_W-1:0]: sel = SEL_LNKHI;
                OFF_PENLO[ADDR_W-1:0]: sel = SEL_PENLO;
                OFF_PENHI[ADDR_W-1:0]: sel = SEL_PENHI;
                default:               sel = SEL_NONE;
            endcase
        end
    end

    logic wr_t32, wr_t64lo, wr_t64hi, wr_irq, wr_penlo, wr_penhi;
    assign wr_t32   = host_wr_en && (sel == SEL_T32);
    assign wr_t64lo = host_wr_en && (sel == SEL_T64LO);
    assign wr_t64hi = host_wr_en && (sel == SEL_T64HI);
    assign wr_irq   = host_wr_en && (sel == SEL_IRQ);
    assign wr_penlo = host_wr_en && (sel == SEL_PENLO);
    assign wr_penhi = host_wr_en && (sel == SEL_PENHI);

    // Hold the last value written to the 32-bit test register
    always_ff @(posedge clk) begin
        if (!rst_n)      t32_q <= '0;
        else if (wr_t32) t32_q <= host_wdata;
    end

    swdev_stage64 #(.HALF_W(HALF_W), .KEEP_MASK('1)) u_t64 (
        .clk(clk), .rst_n(rst_n), .lo_we(wr_t64lo), .hi_we(wr_t64hi),
        .wdata(host_wdata), .value_o(t64_val)
    );

    swdev_stage64 #(.HALF_W(HALF_W), .KEEP_MASK(PORT_MASK)) u_pen (
        .clk(clk), .rst_n(rst_n), .lo_we(wr_penlo), .hi_we(wr_penhi),
        .wdata(host_wdata), .value_o(pen_val)
    );

    swdev_irq_pulse #(.VEC_W(VEC_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .trig(wr_irq), .vec_in(host_wdata[VEC_W-1:0]),
        .valid_o(irq_valid_o), .vector_o(irq_vector_o)
    );

    assign t64_dbl   = t64_val << 1;
    assign lnk_view  = link_up_i & PORT_MASK;
    assign port_en_o = pen_val;

    // Select the read data for the current offset
    always_comb begin
        unique case (sel)
            SEL_TRAP:  host_rdata = TRAP_SIG;
            SEL_T32:   host_rdata = t32_q << 1;
            SEL_T64LO: host_rdata = t64_dbl[31:0];
            SEL_T64HI: host_rdata = t64_dbl[63:32];
            SEL_IRQ:   host_rdata = {{(WORD_W-VEC_W){1'b0}}, irq_vector_o};
            SEL_LNKLO: host_rdata = lnk_view[31:0];
            SEL_LNKHI: host_rdata = lnk_view[63:32];
            SEL_PENLO: host_rdata = pen_val[31:0];
            SEL_PENHI: host_rdata = pen_val[63:32];
            default:   host_rdata = '0;
        endcase
    end

    // R1
    trap_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr < GUARD_END[ADDR_W-1:0]) |-> host_rdata == TRAP_SIG);
    // R3
    t32_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t32 |=> (host_addr != OFF_T32[ADDR_W-1:0] || host_rdata == ($past(host_wdata) << 1)));
    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_irq |=> irq_valid_o && irq_vector_o == $past(host_wdata[7:0]));
    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_irq |=> !irq_valid_o);
    // R7
    pen_edge_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_o[0] && !port_en_o[63]);
endmodule

// File: tb/swdev_regdecode_test.sv
module swdev_regdecode_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] PMASK = {1'b0, {62{1'b1}}, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [12:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [63:0] link_up_i = '0;
    logic [63:0] port_en_o;
    logic        irq_valid_o;
    logic [7:0]  irq_vector_o;

    int checks = 0;
    int fails = 0;

    // Reference model state
    logic [31:0] m_t32 = '0;
    logic [63:0] m_t64 = '0, m_pen = '0;
    logic [31:0] m_t64s = '0, m_pens = '0;
    logic [7:0]  m_vec = '0;

    swdev_regdecode uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    function automatic logic [31:0] exp_read(input logic [12:0] a);
        logic [63:0] d;
        logic [63:0] l;
        d = m_t64 << 1;
        l = link_up_i & PMASK;
        if (a < 13'h10) return 32'hDEADBABE;
        case (a)
            13'h010: return m_t32 << 1;
            13'h018: return d[31:0];
            13'h01C: return d[63:32];
            13'h020: return {24'h0, m_vec};
            13'h310: return l[31:0];
            13'h314: return l[63:32];
            13'h318: return m_pen[31:0];
            13'h31C: return m_pen[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [12:0] a, input logic [31:0] d);
        case (a)
            13'h010: m_t32 = d;
            13'h018: m_t64s = d;
            13'h01C: m_t64 = {d, m_t64s};
            13'h020: m_vec = d[7:0];
            13'h318: m_pens = d;
            13'h31C: m_pen = {d, m_pens} & PMASK;
            default: ;
        endcase
    endtask

    // Write one word, then check the interrupt pulse and the enable output
    task automatic do_write(input logic [12:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(posedge clk);
        #1;
        host_wr_en = 1'b0;
        model_write(a, d);
        check({req, " irq_valid"}, {63'h0, irq_valid_o}, {63'h0, a == 13'h020});
        check({req, " irq_vector"}, {56'h0, irq_vector_o}, {56'h0, m_vec});
        check({req, " R9 port_en_o"}, port_en_o, m_pen);
    endtask

    task automatic do_read(input logic [12:0] a, input string req);
        @(negedge clk);
        host_addr = a;
        #1;
        check(req, {32'h0, host_rdata}, {32'h0, exp_read(a)});
    endtask

    initial begin
        logic [12:0] pool [12];
        pool = '{13'h004, 13'h00C, 13'h010, 13'h011, 13'h014, 13'h018,
                 13'h01C, 13'h020, 13'h310, 13'h314, 13'h318, 13'h31C};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        do_read(13'h010, "R3 reset");
        do_read(13'h018, "R4 reset lo");
        do_read(13'h31C, "R7 reset hi");
        check("R7 reset port_en_o", port_en_o, 64'h0);
        check("R6 reset irq", {63'h0, irq_valid_o}, 64'h0);

        // R1 guard range
        do_write(13'h000, 32'h1234_5678, "R1");
        do_read(13'h000, "R1 trap 0x0");
        do_read(13'h00F, "R1 trap 0xF");
        do_read(13'h010, "R1 no side effect");

        // R3 doubling with top bit dropped
        do_write(13'h010, 32'hC000_0001, "R3");
        do_read(13'h010, "R3 wrap");

        // R5 staging: low alone does nothing, a second low replaces the staged value
        do_write(13'h018, 32'hAAAA_AAAA, "R5");
        do_read(13'h018, "R5 not committed");
        do_write(13'h020, 32'h0000_01F3, "R6");
        do_write(13'h018, 32'h8000_0001, "R5");
        do_read(13'h01C, "R5 still old");
        do_write(13'h01C, 32'h8000_0003, "R4");
        do_read(13'h018, "R4 lo carry");
        do_read(13'h01C, "R4 hi wrap");

        // R6 vector readback and single-cycle pulse
        do_read(13'h020, "R6 readback");
        @(negedge clk);
        check("R6 pulse ends", {63'h0, irq_valid_o}, 64'h0);

        // R7 enable with edge bits forced
        do_write(13'h318, 32'hFFFF_FFFF, "R7");
        check("R5 pen staged only", port_en_o, 64'h0);
        do_write(13'h31C, 32'hFFFF_FFFF, "R7");
        do_read(13'h318, "R7 bit0");
        do_read(13'h31C, "R7 bit63");

        // R8 link view and ignored writes
        link_up_i = 64'hFFFF_FFFF_FFFF_FFFF;
        do_read(13'h310, "R8 lo");
        do_read(13'h314, "R8 hi");
        do_write(13'h310, 32'h0, "R8");
        link_up_i = 64'h8123_4567_89AB_CDEF;
        do_read(13'h310, "R8 lo pattern");
        do_read(13'h314, "R8 hi pattern");

        // R2 unmapped and misaligned
        do_write(13'h014, 32'hFFFF_FFFF, "R2");
        do_write(13'h011, 32'hFFFF_FFFF, "R2");
        do_write(13'h300, 32'hFFFF_FFFF, "R2");
        do_read(13'h014, "R2 hole");
        do_read(13'h011, "R2 misaligned");
        do_read(13'h1000, "R2 far");
        do_read(13'h010, "R2 t32 untouched");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            link_up_i = {$urandom, $urandom};
            do_write(pool[$urandom_range(11)], $urandom, "R4/R5 random");
            do_read(pool[$urandom_range(11)], "R3/R4 random read");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule